// File: doc/BRIEF.md
# Multiplexed Latched-Address Bus Sequencer

This block runs one cycle on an external peripheral bus whose 28-bit address does not fit on its pins. The low twenty address bits go out on dedicated address outputs. The upper eight bits, then bits 19 to 12, then bits 11 to 4 are placed one after another on the shared 8-bit data bus. Each of these three bytes is followed by its own latch strobe, so that external latches can hold it. Once the strobes are up they stay up for the rest of the cycle. After the last byte the block either releases the data bus, for a read, or drives the write byte, for a write. It then raises one of two chip selects together with a read or write strobe.

A data phase of a fixed base of twelve clocks plus a programmed number of wait clocks follows, and during it every output holds still. After that phase the block waits for the peripheral's ready input and then closes the cycle. A read captures the byte on the data bus and returns it, and a one-clock done pulse is given. A host request starts a cycle only when it hits an enabled decoded range. The lowest-numbered enabled range that is hit decides which chip select is used.

Top module: `lat_addr_seq`

## Requirements
- R1: After synchronous reset, latStb, chipSel, rdStb, wrStb, busOe and done are all 0.
- R2: A cycle starts only on a clock edge where the block is idle, reqValid is 1 and rangeHit & rangeEn is nonzero. A request that hits only disabled ranges leaves busOe and latStb at 0.
- R3: At the accepting edge (edge 0), busAddr takes reqAddr[19:0], busDout takes reqAddr[27:20] and busOe goes to 1.
- R4: From edge 4, busDout carries reqAddr[19:12]. From edge 8, busDout carries reqAddr[11:4].
- R5: latStb[2] rises at edge 2, latStb[1] at edge 6 and latStb[0] at edge 10. Each stays 1 until the completing edge, where all three fall together.
- R6: At edge 12, busOe falls to 0 for a read. For a write, busOe stays 1 and busDout takes the captured reqWdata.
- R7: At edge 13, chipSel is driven. Among the ranges with rangeHit & rangeEn set, the lowest-numbered one is chosen: if its rangeCsSel bit is 1, chipSel = 2'b10, otherwise chipSel = 2'b01. rdStb (read) or wrStb (write) rises at the same edge.
- R8: For 12 + waitCount clocks after chip select, all outputs hold steady and busRdy is ignored. The earliest completing edge is edge 26 + waitCount, where waitCount is sampled at edge 0.
- R9: Completion happens at the first edge, from edge 26 + waitCount on, at which busRdy is 1. At that edge, a read loads busDin into rdData, done is 1 for exactly one cycle, and chipSel, rdStb, wrStb, latStb and busOe all return to 0.
- R10: A write cycle leaves rdData unchanged.
- R11: A request that arrives while a cycle is in progress is ignored. The running cycle's outputs are unaffected, and no new cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 28 | Request address |
| reqWdata | input | 8 | Write byte |
| rangeHit | input | 4 | Per-range decode hit for the request |
| rangeEn | input | 4 | Per-range enable |
| rangeCsSel | input | 4 | Per-range chip-select choice (1 = chipSel[1]) |
| waitCount | input | 4 | Programmed extra wait clocks |
| busRdy | input | 1 | Peripheral ready |
| busDin | input | 8 | Data bus value as seen from the pins |
| busDout | output | 8 | Data bus drive value |
| busOe | output | 1 | Data bus drive enable |
| busAddr | output | 20 | Dedicated address outputs |
| latStb | output | 3 | Address-byte latch strobes ([2] upper, [1] middle, [0] lower byte) |
| chipSel | output | 2 | Chip selects |
| rdStb | output | 1 | Read strobe |
| wrStb | output | 1 | Write strobe |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Captured read byte |

## Verification
Two cases are hard to reach from the ports. The first is a ready input that is already high during the wait window, because only a ready seen early shows that the window is really enforced. The bench raises busRdy before the request and holds it there, then checks that done still arrives exactly at edge 26 + waitCount. The second is a request that lands while a cycle is in progress. The bench pulses a fresh request with a different address and direction in the middle of the address phase. It then checks, cycle by cycle, every byte and strobe of the original cycle, and checks that the bus stays idle afterwards.

// File: rtl/lat_addr_pkg.sv
package lat_addr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_RDY  = 2'd3
  } seqState_t;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic loadAddr;  // capture request, put upper byte on bus
    logic putMid;    // put address middle byte on bus
    logic putLow;    // put address lower byte on bus
    logic putWdata;  // put write byte on bus
    logic capture;   // take read byte from bus
  } dpCtl_t;

endpackage

// File: rtl/lat_addr_rsel.sv
module lat_addr_rsel #(
  parameter int NUM_RANGES = 4
) (
  input  logic [NUM_RANGES-1:0] rangeHit,
  input  logic [NUM_RANGES-1:0] rangeEn,
  input  logic [NUM_RANGES-1:0] rangeCsSel,
  output logic                  anyHit,
  output logic                  csPick
);

  logic [NUM_RANGES-1:0] match;
  logic [NUM_RANGES-1:0] firstHot;
  logic [NUM_RANGES:0]   seen;

  assign match   = rangeHit & rangeEn;
  assign seen[0] = 1'b0;

  // Ripple priority: lowest index wins
  for (genvar gi = 0; gi < NUM_RANGES; gi++) begin : g_prio
    assign firstHot[gi]  = match[gi] & ~seen[gi];
    assign seen[gi + 1]  = seen[gi] | match[gi];
  end

  assign anyHit = seen[NUM_RANGES];
  assign csPick = |(firstHot & rangeCsSel);

endmodule

// File: rtl/lat_addr_ctrl.sv
module lat_addr_ctrl
  import lat_addr_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int BASE_WAIT  = 12,
  parameter int STROBE_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              anyHit,
  input  logic              csPick,
  input  logic [WAIT_W-1:0] waitCount,
  input  logic              busRdy,
  output dpCtl_t            dpCtl,
  output logic [2:0]        latStb,
  output logic [1:0]        chipSel,
  output logic              rdStb,
  output logic              wrStb,
  output logic              busOe,
  output logic              done
);

  localparam int PH_STB2 = STROBE_GAP;
  localparam int PH_MID  = 2 * STROBE_GAP;
  localparam int PH_STB1 = 3 * STROBE_GAP;
  localparam int PH_LOW  = 4 * STROBE_GAP;
  localparam int PH_STB0 = 5 * STROBE_GAP;
  localparam int PH_DATA = 6 * STROBE_GAP;
  localparam int PH_CS   = PH_DATA + 1;
  localparam int PH_W    = $clog2(PH_CS + 1);
  localparam int CNT_W   = $clog2(BASE_WAIT + (1 << WAIT_W));

  seqState_t        state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] waitCnt;
  logic             isWrite;
  logic             csBit;
  logic             start;

  assign start = reqValid && anyHit;

  always_comb begin
    dpCtl = '0;
    unique case (state)
      ST_IDLE: dpCtl.loadAddr = start;
      ST_ADDR: begin
        dpCtl.putMid   = (phase == PH_W'(PH_MID));
        dpCtl.putLow   = (phase == PH_W'(PH_LOW));
        dpCtl.putWdata = (phase == PH_W'(PH_DATA)) && isWrite;
      end
      ST_RDY:  dpCtl.capture = busRdy && !isWrite;
      default: dpCtl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= '0;
      waitCnt <= '0;
      isWrite <= 1'b0;
      csBit   <= 1'b0;
      latStb  <= '0;
      chipSel <= '0;
      rdStb   <= 1'b0;
      wrStb   <= 1'b0;
      busOe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ADDR;
            phase   <= PH_W'(1);
            isWrite <= reqWrite;
            csBit   <= csPick;
            waitCnt <= CNT_W'(BASE_WAIT) + CNT_W'(waitCount);
            busOe   <= 1'b1;
          end
        end
        ST_ADDR: begin
          phase <= phase + PH_W'(1);
          if (phase == PH_W'(PH_STB2)) latStb[2] <= 1'b1;
          if (phase == PH_W'(PH_STB1)) latStb[1] <= 1'b1;
          if (phase == PH_W'(PH_STB0)) latStb[0] <= 1'b1;
          if (phase == PH_W'(PH_DATA) && !isWrite) busOe <= 1'b0;
          if (phase == PH_W'(PH_CS)) begin
            chipSel <= csBit ? 2'b10 : 2'b01;
            rdStb   <= !isWrite;
            wrStb   <= isWrite;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (waitCnt <= CNT_W'(1)) state <= ST_RDY;
          else waitCnt <= waitCnt - CNT_W'(1);
        end
        ST_RDY: begin
          if (busRdy) begin
            done    <= 1'b1;
            latStb  <= '0;
            chipSel <= '0;
            rdStb   <= 1'b0;
            wrStb   <= 1'b0;
            busOe   <= 1'b0;
            phase   <= '0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lat_addr_dp.sv
module lat_addr_dp
  import lat_addr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int LOW_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [LOW_W-1:0]  busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic [DATA_W-1:0] rdData
);

  localparam int TOP_HI = ADDR_W - 1;
  localparam int MID_HI = LOW_W - 1;
  localparam int LOW_HI = LOW_W - DATA_W - 1;

  logic [DATA_W-1:0] midByte;
  logic [DATA_W-1:0] lowByte;
  logic [DATA_W-1:0] wdReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr <= '0;
      busDout <= '0;
      rdData  <= '0;
      midByte <= '0;
      lowByte <= '0;
      wdReg   <= '0;
    end else begin
      if (dpCtl.loadAddr) begin
        busAddr <= reqAddr[LOW_W-1:0];
        busDout <= reqAddr[TOP_HI -: DATA_W];
        midByte <= reqAddr[MID_HI -: DATA_W];
        lowByte <= reqAddr[LOW_HI -: DATA_W];
        wdReg   <= reqWdata;
      end
      if (dpCtl.putMid)   busDout <= midByte;
      if (dpCtl.putLow)   busDout <= lowByte;
      if (dpCtl.putWdata) busDout <= wdReg;
      if (dpCtl.capture)  rdData  <= busDin;
    end
  end

endmodule

// File: rtl/lat_addr_seq.sv
module lat_addr_seq
  import lat_addr_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 28,
  parameter int LOW_W      = 20,
  parameter int DATA_W     = 8,
  parameter int WAIT_W     = 4,
  parameter int BASE_WAIT  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [NUM_RANGES-1:0] rangeHit,
  input  logic [NUM_RANGES-1:0] rangeEn,
  input  logic [NUM_RANGES-1:0] rangeCsSel,
  input  logic [WAIT_W-1:0]     waitCount,
  input  logic                  busRdy,
  input  logic [DATA_W-1:0]     busDin,
  output logic [DATA_W-1:0]     busDout,
  output logic                  busOe,
  output logic [LOW_W-1:0]      busAddr,
  output logic [2:0]            latStb,
  output logic [1:0]            chipSel,
  output logic                  rdStb,
  output logic                  wrStb,
  output logic                  done,
  output logic [DATA_W-1:0]     rdData
);

  dpCtl_t dpCtl;
  logic   anyHit;
  logic   csPick;

  lat_addr_rsel #(.NUM_RANGES(NUM_RANGES)) u_rsel (
    .rangeHit  (rangeHit),
    .rangeEn   (rangeEn),
    .rangeCsSel(rangeCsSel),
    .anyHit    (anyHit),
    .csPick    (csPick)
  );

  lat_addr_ctrl #(
    .WAIT_W   (WAIT_W),
    .BASE_WAIT(BASE_WAIT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .anyHit   (anyHit),
    .csPick   (csPick),
    .waitCount(waitCount),
    .busRdy   (busRdy),
    .dpCtl    (dpCtl),
    .latStb   (latStb),
    .chipSel  (chipSel),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .busOe    (busOe),
    .done     (done)
  );

  lat_addr_dp #(
    .ADDR_W(ADDR_W),
    .LOW_W (LOW_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dpCtl   (dpCtl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .busDin  (busDin),
    .busAddr (busAddr),
    .busDout (busDout),
    .rdData  (rdData)
  );

endmodule

// File: rtl/lat_addr_seq_chk.sv
module lat_addr_seq_chk #(
  parameter int LOW_W  = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] busDout,
  input logic              busOe,
  input logic [LOW_W-1:0]  busAddr,
  input logic [2:0]        latStb,
  input logic [1:0]        chipSel,
  input logic              rdStb,
  input logic              wrStb,
  input logic              done
);

  // Counts the cycles chip select has been high, for the wait-window check
  logic [7:0] csCyc;
  always_ff @(posedge clk) begin
    if (rst) csCyc <= '0;
    else if (|chipSel) csCyc <= (csCyc == 8'hFF) ? csCyc : csCyc + 8'd1;
    else csCyc <= '0;
  end

  // R5: strobes are nested, later ones only while earlier ones are held
  a_r5_stb_nested: assert property (@(posedge clk) disable iff (rst)
    (latStb[0] |-> latStb[1]) and (latStb[1] |-> latStb[2]));

  // R5: strobes fall only all together
  a_r5_stb_fall_together: assert property (@(posedge clk) disable iff (rst)
    $fell(latStb[2]) |-> (latStb == 3'b000));

  // R7: at most one chip select, only after all address bytes are latched
  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chipSel));
  a_r7_cs_after_stb: assert property (@(posedge clk) disable iff (rst)
    (|chipSel) |-> (latStb == 3'b111));

  // R6: bus released during a read data phase, driven during a write
  a_r6_rd_released: assert property (@(posedge clk) disable iff (rst)
    rdStb |-> !busOe);
  a_r6_wr_driven: assert property (@(posedge clk) disable iff (rst)
    wrStb |-> busOe);

  // R8: outputs steady while chip select stays high
  a_r8_hold_steady: assert property (@(posedge clk) disable iff (rst)
    ($past(|chipSel) && (|chipSel)) |->
      ($stable(busDout) && $stable(busOe) && $stable(busAddr) &&
       $stable(latStb) && $stable(rdStb) && $stable(wrStb)));

  // R8: no completion before the base wait window has elapsed
  a_r8_min_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (csCyc >= 8'd13));

  // R9: done is one cycle long and everything is released with it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
    done |-> (chipSel == 2'b00 && latStb == 3'b000 && !busOe && !rdStb && !wrStb));

endmodule

bind lat_addr_seq lat_addr_seq_chk #(.LOW_W(LOW_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busDout(busDout),
  .busOe  (busOe),
  .busAddr(busAddr),
  .latStb (latStb),
  .chipSel(chipSel),
  .rdStb  (rdStb),
  .wrStb  (wrStb),
  .done   (done)
);

// File: tb/lat_addr_seq_bench.sv
`timescale 1ns/1ps
module lat_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqWrite, busRdy;
  logic [27:0] reqAddr;
  logic [7:0]  reqWdata, busDin;
  logic [3:0]  rangeHit, rangeEn, rangeCsSel, waitCount;
  logic [7:0]  busDout, rdData;
  logic        busOe, rdStb, wrStb, done;
  logic [19:0] busAddr;
  logic [2:0]  latStb;
  logic [1:0]  chipSel;

  int   checks = 0;
  int   fails  = 0;
  logic [7:0] lastRd = 8'h00;

  always #4 clk = ~clk;

  lat_addr_seq u_lat_addr_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rangeHit(rangeHit),
    .rangeEn(rangeEn), .rangeCsSel(rangeCsSel), .waitCount(waitCount),
    .busRdy(busRdy), .busDin(busDin), .busDout(busDout), .busOe(busOe),
    .busAddr(busAddr), .latStb(latStb), .chipSel(chipSel), .rdStb(rdStb),
    .wrStb(wrStb), .done(done), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    rangeHit = '0; rangeEn = '0; rangeCsSel = '0; waitCount = '0;
    busRdy = 1'b0; busDin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 latStb", 32'(latStb), 0);
    chk("R1 chipSel", 32'(chipSel), 0);
    chk("R1 busOe", 32'(busOe), 0);
    chk("R1 rd/wr strobes", 32'({rdStb, wrStb}), 0);
    chk("R1 done", 32'(done), 0);
    rst = 1'b0;
  endtask

  task automatic t_miss();
    @(negedge clk);
    reqValid = 1'b1; rangeHit = 4'b0010; rangeEn = 4'b1101;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 disabled hit busOe", 32'(busOe), 0);
      chk("R2 disabled hit latStb", 32'(latStb), 0);
    end
    reqValid = 1'b0; rangeEn = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 no valid busOe", 32'(busOe), 0);
    end
    rangeHit = '0;
  endtask

  task automatic t_cycle(input bit wr, input logic [27:0] addr, input logic [7:0] wd,
                         input logic [3:0] hit, input logic [3:0] en, input logic [3:0] sel,
                         input logic [3:0] w, input int rdyDelay, input bit earlyRdy,
                         input logic [1:0] expCs, input logic [7:0] din, input bit midReq);
    int kc;
    logic [7:0] expDout;
    kc = 26 + int'(w) + rdyDelay;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    rangeHit = hit; rangeEn = en; rangeCsSel = sel; waitCount = w;
    busRdy = earlyRdy; busDin = din;
    @(posedge clk);
    for (int k = 0; k <= kc + 1; k++) begin
      @(negedge clk);
      if (midReq && k == 4) begin
        reqValid = 1'b1; reqAddr = addr ^ 28'h5A5A5A5; reqWrite = ~wr; reqWdata = ~wd;
      end else begin
        reqValid = 1'b0;
      end
      if (k < kc) begin
        chk($sformatf("R3 busAddr k=%0d", k), 32'(busAddr), 32'(addr[19:0]));
        if (k < 4) expDout = addr[27:20];
        else if (k < 8) expDout = addr[19:12];
        else if (k < 12) expDout = addr[11:4];
        else expDout = wd;
        if (k < 12 || wr)
          chk($sformatf("%s busDout k=%0d", (k < 4) ? "R3" : (k < 12) ? "R4" : "R6", k),
              32'(busDout), 32'(expDout));
        chk($sformatf("R5 latStb k=%0d", k), 32'(latStb),
            32'({k >= 2, k >= 6, k >= 10}));
        chk($sformatf("%s busOe k=%0d", (k < 12) ? "R3" : "R6", k), 32'(busOe),
            32'((k < 12) || wr));
        chk($sformatf("R7 chipSel k=%0d", k), 32'(chipSel), (k >= 13) ? 32'(expCs) : 0);
        chk($sformatf("R7 rdStb/wrStb k=%0d", k), 32'({rdStb, wrStb}),
            (k >= 13) ? 32'({!wr, wr}) : 0);
        chk($sformatf("R8 no early done k=%0d", k), 32'(done), 0);
      end else if (k == kc) begin
        chk("R9 done at completion", 32'(done), 1);
        chk("R9 chipSel released", 32'(chipSel), 0);
        chk("R5 latStb fall together", 32'(latStb), 0);
        chk("R9 busOe released", 32'(busOe), 0);
        chk("R9 rd/wr strobes released", 32'({rdStb, wrStb}), 0);
        if (wr) chk("R10 rdData unchanged by write", 32'(rdData), 32'(lastRd));
        else    chk("R9 rdData captured", 32'(rdData), 32'(din));
      end else begin
        chk("R9 done one cycle", 32'(done), 0);
      end
      busRdy = earlyRdy || (k + 1 >= kc);
      if (k < kc + 1) @(posedge clk);
    end
    if (!wr) lastRd = din;
    busRdy = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(midReq ? "R11 no cycle after busy request" : "R9 idle after done",
          32'({busOe, latStb}), 0);
    end
    rangeHit = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_miss();
    // read, wait 0, range 0 picks chipSel[0]
    t_cycle(1'b0, 28'hABC_DE12, 8'h00, 4'b0001, 4'b0001, 4'b0000, 4'd0, 0, 1'b0, 2'b01, 8'h3C, 1'b0);
    // write, wait 3, range 1 mapped to chipSel[1]
    t_cycle(1'b1, 28'h123_4567, 8'hA5, 4'b0010, 4'b0011, 4'b0010, 4'd3, 0, 1'b0, 2'b10, 8'hFF, 1'b0);
    // R8: ready high from the start, still waits the full window
    t_cycle(1'b0, 28'hF0F_0F0F, 8'h00, 4'b0100, 4'b0100, 4'b0000, 4'd2, 0, 1'b1, 2'b01, 8'h96, 1'b0);
    // R9: ready stalled five extra clocks, max wait count
    t_cycle(1'b0, 28'h55A_A55A, 8'h00, 4'b1000, 4'b1000, 4'b1000, 4'd15, 5, 1'b0, 2'b10, 8'h71, 1'b0);
    // R7: lowest enabled hit wins (range 2, mapped to chipSel[1])
    t_cycle(1'b1, 28'h0F1_2345, 8'h5E, 4'b1110, 4'b1100, 4'b0100, 4'd1, 0, 1'b0, 2'b10, 8'h00, 1'b0);
    // R7: range 0 wins over higher ranges mapped to chipSel[1]
    t_cycle(1'b0, 28'h987_6543, 8'h00, 4'b1011, 4'b1111, 4'b1110, 4'd0, 2, 1'b0, 2'b01, 8'hC3, 1'b0);
    // R11: request during the address phase is ignored
    t_cycle(1'b0, 28'h246_8ACE, 8'h11, 4'b0001, 4'b0001, 4'b0000, 4'd1, 1, 1'b0, 2'b01, 8'h2B, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule